// File: doc/BRIEF.md
# Block-Buffered Host Data Mover

This block moves data between a byte-wide host register bus and a byte stream on the SCSI side. It does so in fixed 128-byte blocks through a single buffer. The host picks a direction in the control register and then writes a nonzero block count. After that it moves each block through one data port. Before each block it polls a not-ready flag in the status register.

In a read transfer, the SCSI side fills the buffer and then the host empties it. In a write transfer, the host fills the buffer and then the SCSI side drains it. After each block the count drops by one. When the count reaches zero, register access returns to the core, an end-of-transfer flag is set and the interrupt rises. If the core raises an interrupt while a transfer runs, the transfer stops at once and the remaining count is kept.

Top module: `pdma_blkbuf`

## Requirements
- R1: After reset the status register (offset 9) reads 0x80, the count register (offset 10) reads 0, `irq` is low, `sin_ready` is low and `sout_valid` is low.
- R2: While idle, a write to offset 9 latches bit 6 as the direction (1 = SCSI to host, 0 = host to SCSI). Bit 6 always reads back as 0, so writing 0xC0 reads back 0x80.
- R3: While idle, writing a nonzero value N to offset 10 starts a transfer of N blocks. Offset 10 then reads N and status bit 7 (core registers available) reads 0. Writing 0 does not start a transfer. Writes to offsets 9 and 10 during a transfer are ignored.
- R4: In a read transfer, status bit 2 (not ready) is set and `sin_ready` is high until 128 bytes have been taken from `sin_data`. Bit 2 then clears, and reads of offset 8 return those bytes in arrival order.
- R5: In a write transfer, bit 2 is clear while the buffer is empty. After 128 host writes to offset 8, bit 2 sets and the bytes leave on `sout_data` in write order. Bit 2 clears again once they have drained.
- R6: The count drops by exactly one per completed block. In a read this happens after the 128th host read; in a write, after the 128th byte is sent.
- R7: A data-port access while bit 2 is set is ignored. A write stores nothing and a read does not advance the buffer.
- R8: When the count reaches zero, status bit 7, bit 1 (end of transfer) and bit 0 (interrupt) all set, so status reads 0x83, and `irq` goes high.
- R9: `core_irq` high during a transfer ends it at the next edge. Status bits 7 and 0 and `irq` set, bit 1 stays clear, and the count keeps the number of blocks not yet finished.
- R10: An idle write to offset 9 clears status bits 0 and 1 and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset |
| sin_data | input | 8 | SCSI-side byte into the buffer |
| sin_valid | input | 1 | `sin_data` is valid |
| sin_ready | output | 1 | Buffer takes a byte |
| sout_data | output | 8 | Byte from the buffer to the SCSI side |
| sout_valid | output | 1 | `sout_data` is valid |
| sout_ready | input | 1 | SCSI side takes the byte |
| core_irq | input | 1 | Interrupt request from the core |
| irq | output | 1 | Gated interrupt |

## Verification
Every cycle, the assertions check four things: that a transfer starts with the written count, that the count moves by at most one per cycle, that an interrupt from the core stops the transfer without flagging end of transfer, and that end of transfer appears only with a zero count. Byte ordering through the buffer, the ignored data-port accesses while not ready, and the readback of the control bits can only be shown by the bench's scenarios. The bench covers a two-block read, a one-block write with a stalled drain, and an aborted read.

// File: rtl/pdma_blkbuf.sv
module pdma_blkbuf #(
  parameter int BLK_BYTES = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] sin_data,
  input  logic       sin_valid,
  output logic       sin_ready,
  output logic [7:0] sout_data,
  output logic       sout_valid,
  input  logic       sout_ready,
  input  logic       core_irq,
  output logic       irq
);
  localparam int PW = $clog2(BLK_BYTES);
  localparam logic [3:0] A_DATA = 4'd8;
  localparam logic [3:0] A_CTRL = 4'd9;
  localparam logic [3:0] A_CNT  = 4'd10;

  logic [7:0]    mem [BLK_BYTES];
  logic [PW-1:0] ptr;
  logic [7:0]    blk_cnt;
  logic active, dir_rd, host_own, end_dma, irq_flag;

  logic not_ready, host_acc, scsi_acc, step, at_last, blk_done, start, abort, ctrl_wr, buf_wr;

  assign not_ready  = active & ~host_own;
  assign sin_ready  = active & dir_rd & ~host_own;
  assign sout_valid = active & ~dir_rd & ~host_own;
  assign sout_data  = mem[ptr];
  assign host_acc   = active & host_own & (reg_addr == A_DATA) & (dir_rd ? reg_rd : reg_wr);
  assign scsi_acc   = dir_rd ? (sin_valid & sin_ready) : (sout_valid & sout_ready);
  assign step       = host_acc | scsi_acc;
  assign at_last    = ptr == PW'(BLK_BYTES - 1);
  assign blk_done   = at_last & (dir_rd ? host_acc : scsi_acc);
  assign start      = ~active & reg_wr & (reg_addr == A_CNT) & (reg_wdata != 8'd0);
  assign abort      = active & core_irq;
  assign ctrl_wr    = ~active & reg_wr & (reg_addr == A_CTRL);
  assign buf_wr     = dir_rd ? scsi_acc : host_acc;
  assign irq        = irq_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; blk_cnt <= '0; active <= 1'b0; dir_rd <= 1'b0;
      host_own <= 1'b0; end_dma <= 1'b0; irq_flag <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1; blk_cnt <= reg_wdata; ptr <= '0;
        host_own <= ~dir_rd; end_dma <= 1'b0;
      end else if (abort) begin
        active <= 1'b0; irq_flag <= 1'b1;
      end else if (step) begin
        ptr <= at_last ? '0 : ptr + 1'b1;
        if (at_last) host_own <= ~host_own;
        if (blk_done) begin
          blk_cnt <= blk_cnt - 1'b1;
          if (blk_cnt == 8'd1) begin
            active <= 1'b0; end_dma <= 1'b1; irq_flag <= 1'b1;
          end
        end
      end
      if (ctrl_wr) begin
        dir_rd <= reg_wdata[6]; irq_flag <= 1'b0; end_dma <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (buf_wr) mem[ptr] <= dir_rd ? sin_data : reg_wdata;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = (active & dir_rd & host_own) ? mem[ptr] : 8'h00;
      A_CTRL:  reg_rdata = {~active, 4'b0000, not_ready, end_dma, irq_flag};
      A_CNT:   reg_rdata = blk_cnt;
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && reg_wr && reg_addr == A_CNT && reg_wdata != 8'd0) |=> (active && blk_cnt == $past(reg_wdata))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (blk_cnt == $past(blk_cnt) || blk_cnt == $past(blk_cnt) - 8'd1)); // R6
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_dma) |-> (blk_cnt == 8'd0 && irq && !active)); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && core_irq) |=> (!active && irq && !end_dma)); // R9
endmodule

// File: tb/pdma_blkbuf_tb_top.sv
module pdma_blkbuf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] sin_data = '0, sout_data;
  logic sin_valid = 1'b0, sin_ready, sout_valid, sout_ready = 1'b0;
  logic core_irq = 1'b0, irq;

  int n_chk = 0, n_fail = 0, mon_bad = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  pdma_blkbuf dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic feed(input int n, input logic [7:0] seed);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sin_valid = 1'b1; sin_data = seed + 8'(i * 7);
      #1 if (!sin_ready) miss++;
      exp_q.push_back(sin_data);
    end
    @(negedge clk); sin_valid = 1'b0;
    chk("R4 sin_ready high while filling", miss, 0);
  endtask

  task automatic host_drain_block();
    int bad = 0;
    logic [7:0] v, e;
    for (int i = 0; i < 128; i++) begin
      rd(4'd8, v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      if (v !== e) bad++;
    end
    chk("R4 host reads in arrival order", bad, 0);
  endtask

  always begin
    @(negedge clk); #3;
    if (sout_valid && sout_ready) begin
      if (exp_q.size() == 0) mon_bad++;
      else if (exp_q.pop_front() !== sout_data) mon_bad++;
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd9, v);  chk("R1 status after reset", v, 8'h80);
    rd(4'd10, v); chk("R1 count after reset", v, 0);
    chk("R1 irq/sin_ready/sout_valid low", {irq, sin_ready, sout_valid}, 0);

    wr(4'd9, 8'hC0);
    rd(4'd9, v); chk("R2 0xC0 reads back 0x80", v, 8'h80);

    wr(4'd10, 8'd0);
    rd(4'd10, v); chk("R3 zero count ignored", v, 0);
    rd(4'd9, v);  chk("R3 zero count leaves idle", v, 8'h80);

    wr(4'd10, 8'd2);
    rd(4'd10, v); chk("R3 count loaded", v, 2);
    rd(4'd9, v);  chk("R3 R4 busy and not ready", v, 8'h04);
    rd(4'd8, v);  chk("R7 read while not ready gives 0", v, 0);
    wr(4'd10, 8'd5);
    rd(4'd10, v); chk("R3 count write while active ignored", v, 2);
    feed(128, 8'h11);
    rd(4'd9, v);  chk("R4 not ready clears after fill", v, 8'h00);
    chk("R4 sin_ready low when host owns", sin_ready, 0);
    host_drain_block();
    rd(4'd10, v); chk("R6 count after first block", v, 1);
    rd(4'd9, v);  chk("R4 not ready again for next block", v, 8'h04);
    feed(128, 8'h80);
    host_drain_block();
    rd(4'd10, v); chk("R6 count reaches zero", v, 0);
    rd(4'd9, v);  chk("R8 status at completion", v, 8'h83);
    chk("R8 irq high", irq, 1);

    wr(4'd9, 8'h00);
    rd(4'd9, v);  chk("R10 control write clears flags", v, 8'h80);
    chk("R10 irq low", irq, 0);

    wr(4'd10, 8'd1);
    rd(4'd9, v);  chk("R5 empty buffer ready", v, 8'h00);
    for (int i = 0; i < 128; i++) begin
      wr(4'd8, 8'(8'hA5 ^ 8'(i * 3)));
      exp_q.push_back(8'(8'hA5 ^ 8'(i * 3)));
    end
    rd(4'd9, v);  chk("R5 not ready after full", v, 8'h04);
    chk("R5 sout_valid while draining", sout_valid, 1);
    wr(4'd8, 8'hEE);
    @(negedge clk); sout_ready = 1'b1;
    repeat (140) @(negedge clk);
    sout_ready = 1'b0;
    chk("R5 R7 drain order, no extra byte", mon_bad, 0);
    chk("R5 all bytes drained", exp_q.size(), 0);
    rd(4'd10, v); chk("R6 write count zero", v, 0);
    rd(4'd9, v);  chk("R8 write completion status", v, 8'h83);

    wr(4'd9, 8'h40);
    wr(4'd10, 8'd3);
    feed(10, 8'h30);
    exp_q.delete();
    @(negedge clk); core_irq = 1'b1;
    @(posedge clk); #1 core_irq = 1'b0;
    rd(4'd9, v);  chk("R9 abort status", v, 8'h81);
    rd(4'd10, v); chk("R9 count kept", v, 3);
    chk("R9 irq high", irq, 1);
    wr(4'd9, 8'h00);
    rd(4'd9, v);  chk("R10 clear after abort", v, 8'h80);

    finish_up();
  end
endmodule